// File: doc/BRIEF.md
# Processor Trace Nibble Stream Encoder

This block converts execution events reported by a processor core into a dense stream of 4-bit codes on a debug trace port. Each trace clock carries two nibble slots on an 8-bit output. The first slot is in bits [7:4] and the second is in bits [3:0]. A valid flag marks cycles that carry trace content.

Four kinds of event arrive as single-cycle strobes:

- a taken branch through a computed address, with its target;
- entry to a stopped state;
- exit from the stopped state;
- a change in breakpoint trigger status.

A small configuration register sets whether the branch target follows the branch code, and if so how many of its bytes. When the target is sent, a size marker precedes it and the nibbles go out least significant first.

Multi-nibble packets wait in an internal nibble queue, so packets never interleave. Unused slots carry an idle code. While the core is stopped, every free slot carries the halt code. A packet that does not fit in the queue is dropped whole, and an overflow pulse is raised.

Top module: `trace_nibble_encoder`

## Requirements
- R1: While rst_n is low at a clock edge, the port is cleared: trc_data = 0x00, trc_valid = 0 and trc_overflow = 0. The target-size setting also returns to code 0 (target display disabled).
- R2: Target display is disabled when the size setting is 0. A taken branch then queues the single nibble 0x5. If no other nibble follows it, that nibble leaves as the byte 0x50.
- R3: Target display is enabled when the size setting is 1, 2 or 3. The 0x5 is then followed by a marker nibble of 0x9, 0xA or 0xB. The marker is followed by 4, 6 or 8 target nibbles (2, 3 or 4 bytes).
- R4: Nibbles leave in queue order, the earlier one in trc_data[7:4]. Target nibbles are sent from bit [3:0] upward. A 2-byte target 0x1234 therefore gives the bytes 0x59, 0x43 and 0x21.
- R5: A breakpoint change queues the nibble 0xE followed by the trigger status moved left one bit. The status input is right justified, with these codes:

  | bkpt_status | Meaning | Nibble sent |
  |---|---|---|
  | 0 | no breakpoints enabled | 0x0 |
  | 1 | waiting for level 1 | 0x2 |
  | 2 | level 1 triggered | 0x4 |
  | 5 | waiting for level 2 | 0xA |
  | 6 | level 2 triggered | 0xC |

- R6: After stop_enter, every slot not filled from the queue carries 0xE. This continues up to and including the byte built at the edge where stop_exit is sampled. The byte after that is idle.
- R7: A stop entry and a breakpoint change in the same cycle emit the breakpoint packet first. The continuous 0xE fill follows it.
- R8: With the queue empty and the core not stopped, the port shows 0x00 with trc_valid = 0.
- R9: A breakpoint change and a branch in the same cycle are queued with the breakpoint packet first. Every accepted nibble leaves exactly once, in order, with no packet split by another event.
- R10: A packet that does not fit in the queue's free space is rejected with all other events of that cycle. trc_overflow is then 1 for exactly the following cycle, and no nibble of the rejected cycle appears.
- R11: An event sampled at clock edge k with an empty queue shows on the port after edge k+1. After edge k the port is still idle.
- R12: A write with cfg_we = 1 loads cfg_addr_size at the clock edge. Events in later cycles use the new size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Trace clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Load strobe for the target-size setting |
| cfg_addr_size | input | 2 | Target bytes shown: 0 none, 1 two, 2 three, 3 four |
| br_taken | input | 1 | Taken computed-address branch this cycle |
| br_target | input | ADDR_W | Branch target address |
| stop_enter | input | 1 | Core enters the stopped state |
| stop_exit | input | 1 | Core leaves the stopped state (wins over stop_enter) |
| bkpt_chg | input | 1 | Breakpoint trigger status changed |
| bkpt_status | input | 3 | Right-justified trigger status code |
| trc_data | output | 8 | Two nibble slots, first slot in [7:4] |
| trc_valid | output | 1 | Cycle carries queued or halt content |
| trc_overflow | output | 1 | One-cycle pulse: a cycle's packets were dropped |

## Verification
The hardest state to reach from the ports is a full queue. The port drains two nibbles per cycle, and most packets are shorter than that backlog. The stimulus reaches it by setting the widest target size and holding br_taken high for two consecutive cycles. The first ten-nibble packet leaves too little room for the second, so the second is refused.

The breakpoint-before-halt ordering also needs care: both strobes are raised in one cycle. The bench then expects the breakpoint byte to appear before any 0xE fill.

// File: rtl/trc_pkg.sv
// Shared nibble codes and the target-size encoding for the trace encoder.
// Assumes a 4-bit nibble slot; nothing here holds state.
package trc_pkg;
    typedef logic [3:0] nib_t;

    localparam nib_t NIB_IDLE   = 4'h0;
    localparam nib_t NIB_BRANCH = 4'h5;
    localparam nib_t NIB_HALT   = 4'hE;
    localparam nib_t NIB_MARK   = 4'h8;

    // Target bytes shown after a branch code
    typedef enum logic [1:0] {
        ASZ_OFF = 2'd0,
        ASZ_2B  = 2'd1,
        ASZ_3B  = 2'd2,
        ASZ_4B  = 2'd3
    } addr_size_e;
endpackage

// File: rtl/trc_packet_builder.sv
// Builds the nibble packet for one cycle's events: breakpoint packet first,
// then the branch packet. Purely combinational. Assumes ADDR_W >= 32 so that
// a four-byte target exists, and that unused positions are don't-care.
module trc_packet_builder
    import trc_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int MAX_NIBS = 4 + ADDR_W / 4,
    parameter int LEN_W    = $clog2(MAX_NIBS + 1)
) (
    input  logic                        br_taken,
    input  logic [ADDR_W-1:0]           br_target,
    input  logic                        bkpt_chg,
    input  logic [2:0]                  bkpt_status,
    input  addr_size_e                  size,
    output logic [MAX_NIBS-1:0][3:0]    pkt_nib,
    output logic [LEN_W-1:0]            pkt_len
);
    int bk_len;
    int hdr;
    int tgt_len;
    int br_len;
    int rel;
    int aidx;
    logic [ADDR_W-1:0] shifted;

    // Lengths of each part of the packet
    always_comb begin
        bk_len  = bkpt_chg ? 2 : 0;
        hdr     = (size != ASZ_OFF) ? 1 : 0;
        tgt_len = (size != ASZ_OFF) ? 2 * (int'(size) + 1) : 0;
        br_len  = br_taken ? (1 + hdr + tgt_len) : 0;
        pkt_len = LEN_W'(bk_len + br_len);
    end

    // Place each nibble position from the breakpoint or branch part
    always_comb begin
        for (int j = 0; j < MAX_NIBS; j++) begin
            rel  = j - bk_len;
            aidx = rel - 1 - hdr;
            if (aidx < 0) aidx = 0;
            shifted = br_target >> (4 * aidx);
            if (j < bk_len) begin
                pkt_nib[j] = (j == 0) ? NIB_HALT : {bkpt_status, 1'b0};
            end else if (rel == 0) begin
                pkt_nib[j] = NIB_BRANCH;
            end else if (rel == 1 && hdr == 1) begin
                pkt_nib[j] = NIB_MARK | {2'b00, size};
            end else begin
                pkt_nib[j] = shifted[3:0];
            end
        end
    end
endmodule

// File: rtl/trc_nibble_fifo.sv
// Nibble queue that accepts a whole packet per cycle and releases up to two.
// Assumes the caller never pushes more than the free space and never pops
// more than the level; MAX_PUSH must not exceed the depth.
module trc_nibble_fifo
    import trc_pkg::*;
#(
    parameter int DEPTH_LOG2 = 4,
    parameter int MAX_PUSH   = 12,
    parameter int DEPTH      = 1 << DEPTH_LOG2,
    parameter int CNT_W      = DEPTH_LOG2 + 1,
    parameter int PW         = $clog2(MAX_PUSH + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [MAX_PUSH-1:0][3:0]  push_nib,
    input  logic [PW-1:0]             push_len,
    input  logic [1:0]                pop_len,
    output nib_t                      head0,
    output nib_t                      head1,
    output logic [CNT_W-1:0]          level
);
    nib_t                  mem [DEPTH];
    logic [DEPTH_LOG2-1:0] wptr;
    logic [DEPTH_LOG2-1:0] rptr;

    // Store the accepted nibbles at consecutive slots
    always_ff @(posedge clk) begin
        for (int i = 0; i < MAX_PUSH; i++) begin
            if (PW'(i) < push_len) mem[wptr + DEPTH_LOG2'(i)] <= push_nib[i];
        end
    end

    // Advance pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            wptr  <= wptr + DEPTH_LOG2'(push_len);
            rptr  <= rptr + DEPTH_LOG2'(pop_len);
            level <= level + CNT_W'(push_len) - CNT_W'(pop_len);
        end
    end

    assign head0 = mem[rptr];
    assign head1 = mem[rptr + DEPTH_LOG2'(1)];

    p_pop_within_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pop_len) <= int'(level));
    p_push_fits_r10: assert property (@(posedge clk) disable iff (!rst_n)
        int'(push_len) <= DEPTH - int'(level));
    p_level_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        int'(level) <= DEPTH);
endmodule

// File: rtl/trc_slot_mux.sv
// Fills the two port slots each cycle from the queue head, then with the
// halt code while stopped, else with the idle code; registers the result.
// Assumes head0/head1 are meaningful only when the level covers them.
module trc_slot_mux
    import trc_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  level,
    input  nib_t              head0,
    input  nib_t              head1,
    input  logic              halted,
    output logic [1:0]        pop_len,
    output logic [7:0]        trc_data,
    output logic              trc_valid
);
    nib_t fill;
    logic [7:0] slots;
    logic busy;

    // Pick slot contents and how many queue nibbles they consume
    always_comb begin
        fill = halted ? NIB_HALT : NIB_IDLE;
        if (level == '0) begin
            slots   = {fill, fill};
            pop_len = 2'd0;
            busy    = halted;
        end else if (level == CNT_W'(1)) begin
            slots   = {head0, fill};
            pop_len = 2'd1;
            busy    = 1'b1;
        end else begin
            slots   = {head0, head1};
            pop_len = 2'd2;
            busy    = 1'b1;
        end
    end

    // Register the port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trc_data  <= 8'h00;
            trc_valid <= 1'b0;
        end else begin
            trc_data  <= slots;
            trc_valid <= busy;
        end
    end

    p_idle_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0 && !halted) |=> (trc_data == 8'h00 && !trc_valid));
    p_halt_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0 && halted) |=> (trc_data == 8'hEE && trc_valid));
    p_head_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (level != '0) |=> (trc_data[7:4] == $past(head0)));
endmodule

// File: rtl/trace_nibble_encoder.sv
// Top of the trace nibble encoder: holds the target-size setting and the
// stopped flag, builds packets, rejects packets that do not fit, queues
// them and drives the two-slot port. Assumes 4 + ADDR_W/4 <= 2**FIFO_LOG2.
module trace_nibble_encoder
    import trc_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int FIFO_LOG2 = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr_size,
    input  logic              br_taken,
    input  logic [ADDR_W-1:0] br_target,
    input  logic              stop_enter,
    input  logic              stop_exit,
    input  logic              bkpt_chg,
    input  logic [2:0]        bkpt_status,
    output logic [7:0]        trc_data,
    output logic              trc_valid,
    output logic              trc_overflow
);
    localparam int PKT_MAX = 4 + ADDR_W / 4;
    localparam int LEN_W   = $clog2(PKT_MAX + 1);
    localparam int DEPTH   = 1 << FIFO_LOG2;
    localparam int CNT_W   = FIFO_LOG2 + 1;

    addr_size_e               size_q;
    logic                     halted_q;
    logic [PKT_MAX-1:0][3:0]  pkt_nib;
    logic [LEN_W-1:0]         pkt_len;
    logic [LEN_W-1:0]         push_len;
    logic [CNT_W-1:0]         fifo_level;
    logic [1:0]               pop_len;
    nib_t                     head0;
    nib_t                     head1;
    logic                     fits;

    // Target-size setting
    always_ff @(posedge clk) begin
        if (!rst_n)      size_q <= ASZ_OFF;
        else if (cfg_we) size_q <= addr_size_e'(cfg_addr_size);
    end

    // Stopped flag; exit wins over entry
    always_ff @(posedge clk) begin
        if (!rst_n)          halted_q <= 1'b0;
        else if (stop_exit)  halted_q <= 1'b0;
        else if (stop_enter) halted_q <= 1'b1;
    end

    trc_packet_builder #(
        .ADDR_W   (ADDR_W),
        .MAX_NIBS (PKT_MAX),
        .LEN_W    (LEN_W)
    ) u_build (
        .br_taken    (br_taken),
        .br_target   (br_target),
        .bkpt_chg    (bkpt_chg),
        .bkpt_status (bkpt_status),
        .size        (size_q),
        .pkt_nib     (pkt_nib),
        .pkt_len     (pkt_len)
    );

    // Accept the cycle's packets only if all of them fit
    always_comb begin
        fits     = int'(pkt_len) <= (DEPTH - int'(fifo_level));
        push_len = fits ? pkt_len : '0;
    end

    // One-cycle overflow pulse
    always_ff @(posedge clk) begin
        if (!rst_n) trc_overflow <= 1'b0;
        else        trc_overflow <= (pkt_len != '0) && !fits;
    end

    trc_nibble_fifo #(
        .DEPTH_LOG2 (FIFO_LOG2),
        .MAX_PUSH   (PKT_MAX),
        .DEPTH      (DEPTH),
        .CNT_W      (CNT_W),
        .PW         (LEN_W)
    ) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_nib (pkt_nib),
        .push_len (push_len),
        .pop_len  (pop_len),
        .head0    (head0),
        .head1    (head1),
        .level    (fifo_level)
    );

    trc_slot_mux #(
        .CNT_W (CNT_W)
    ) u_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .level     (fifo_level),
        .head0     (head0),
        .head1     (head1),
        .halted    (halted_q),
        .pop_len   (pop_len),
        .trc_data  (trc_data),
        .trc_valid (trc_valid)
    );

    p_cfg_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(size_q));
    p_exit_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stop_exit |=> !halted_q);
    p_overflow_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (trc_overflow && !($past(br_taken) && $past(bkpt_chg))) |-> !$past(trc_overflow) || $past(br_taken) || $past(bkpt_chg));
    p_stop_enter_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_enter && !stop_exit) |=> halted_q);
endmodule

// File: tb/trace_nibble_encoder_tb.sv
`timescale 1ns/1ps
module trace_nibble_encoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr_size = 2'd0;
    logic        br_taken = 1'b0;
    logic [31:0] br_target = '0;
    logic        stop_enter = 1'b0;
    logic        stop_exit = 1'b0;
    logic        bkpt_chg = 1'b0;
    logic [2:0]  bkpt_status = '0;
    logic [7:0]  trc_data;
    logic        trc_valid;
    logic        trc_overflow;

    int checks = 0;
    int fails = 0;
    int cur_size = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [3:0] nq[$];

    always #5 clk = ~clk;

    trace_nibble_encoder u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr_size(cfg_addr_size),
        .br_taken(br_taken), .br_target(br_target), .stop_enter(stop_enter),
        .stop_exit(stop_exit), .bkpt_chg(bkpt_chg), .bkpt_status(bkpt_status),
        .trc_data(trc_data), .trc_valid(trc_valid), .trc_overflow(trc_overflow)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Pack queued model nibbles into expected bytes, padding with idle
    task automatic flush(input string tag);
        logic [3:0] a;
        logic [3:0] b;
        while (nq.size() > 0) begin
            a = nq.pop_front();
            b = (nq.size() > 0) ? nq.pop_front() : 4'h0;
            exp_q.push_back({a, b});
            tag_q.push_back(tag);
        end
    endtask

    task automatic model_bkpt(input logic [2:0] st);
        nq.push_back(4'hE);
        nq.push_back({st, 1'b0});
    endtask

    task automatic model_branch(input logic [31:0] t);
        nq.push_back(4'h5);
        if (cur_size != 0) begin
            nq.push_back(4'h8 + 4'(cur_size));
            for (int i = 0; i < 2 * (cur_size + 1); i++) nq.push_back(t[4*i +: 4]);
        end
    endtask

    task automatic drain();
        repeat (8) @(negedge clk);
    endtask

    task automatic set_size(input int s);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_addr_size = 2'(s);
        @(negedge clk);
        cfg_we = 1'b0;
        cur_size = s;
    endtask

    task automatic do_branch(input logic [31:0] t, input string tag);
        @(negedge clk);
        br_taken = 1'b1;
        br_target = t;
        model_branch(t);
        flush(tag);
        @(negedge clk);
        br_taken = 1'b0;
        drain();
    endtask

    task automatic do_bkpt(input logic [2:0] st, input string tag);
        @(negedge clk);
        bkpt_chg = 1'b1;
        bkpt_status = st;
        model_bkpt(st);
        flush(tag);
        @(negedge clk);
        bkpt_chg = 1'b0;
        drain();
    endtask

    // Monitor: every valid byte must match the next expected one
    always @(negedge clk) begin
        if (rst_n && trc_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9 unexpected byte", {24'h0, trc_data}, 32'h0);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(trc_data == e, t, {24'h0, trc_data}, {24'h0, e});
            end
        end
    end

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(trc_data == 8'h00, "R1 data in reset", {24'h0, trc_data}, 32'h0);
        chk(trc_valid == 1'b0, "R1 valid in reset", {31'h0, trc_valid}, 32'h0);
        chk(trc_overflow == 1'b0, "R1 overflow in reset", {31'h0, trc_overflow}, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(trc_data == 8'h00 && !trc_valid, "R8 idle after reset", {23'h0, trc_valid, trc_data}, 32'h0);

        // R1 R2: size defaults to disabled, branch is a lone 0x5
        do_branch(32'hDEADBEEF, "R1 R2 default disabled branch");

        // R3 R4 R12: each target size
        set_size(1);
        do_branch(32'h00001234, "R3 R4 R12 two-byte target");
        set_size(2);
        do_branch(32'h00ABCDEF, "R3 R12 three-byte target");
        set_size(3);
        do_branch(32'h89ABCDEF, "R3 R4 four-byte target");
        set_size(0);
        do_branch(32'h11111111, "R2 R12 disabled again");

        // R11: latency of a breakpoint packet
        @(negedge clk);
        bkpt_chg = 1'b1;
        bkpt_status = 3'd2;
        model_bkpt(3'd2);
        flush("R5 R11 bkpt level1 triggered");
        @(negedge clk);
        bkpt_chg = 1'b0;
        chk(trc_valid == 1'b0, "R11 still idle after event edge", {31'h0, trc_valid}, 32'h0);
        @(negedge clk);
        chk(trc_valid == 1'b1, "R11 output one edge later", {31'h0, trc_valid}, 32'h1);
        drain();

        // R5: all status codes
        do_bkpt(3'd0, "R5 none enabled");
        do_bkpt(3'd1, "R5 waiting level1");
        do_bkpt(3'd5, "R5 waiting level2");
        do_bkpt(3'd6, "R5 level2 triggered");

        // R9: breakpoint and branch in one cycle
        set_size(1);
        @(negedge clk);
        bkpt_chg = 1'b1;
        bkpt_status = 3'd5;
        br_taken = 1'b1;
        br_target = 32'h0000CAFE;
        model_bkpt(3'd5);
        model_branch(32'h0000CAFE);
        flush("R9 bkpt before branch");
        @(negedge clk);
        bkpt_chg = 1'b0;
        br_taken = 1'b0;
        drain();

        // R6: stop stream lasting W+1 bytes
        @(negedge clk);
        stop_enter = 1'b1;
        @(negedge clk);
        stop_enter = 1'b0;
        for (int i = 0; i < 5; i++) begin
            exp_q.push_back(8'hEE);
            tag_q.push_back("R6 halt fill");
        end
        repeat (4) @(negedge clk);
        stop_exit = 1'b1;
        @(negedge clk);
        stop_exit = 1'b0;
        @(negedge clk);
        chk(trc_data == 8'h00 && !trc_valid, "R6 idle after exit", {23'h0, trc_valid, trc_data}, 32'h0);
        drain();

        // R7: stop and breakpoint together
        @(negedge clk);
        stop_enter = 1'b1;
        bkpt_chg = 1'b1;
        bkpt_status = 3'd6;
        exp_q.push_back(8'hEC);
        tag_q.push_back("R7 bkpt before halt");
        @(negedge clk);
        stop_enter = 1'b0;
        bkpt_chg = 1'b0;
        for (int i = 0; i < 4; i++) begin
            exp_q.push_back(8'hEE);
            tag_q.push_back("R7 halt fill after bkpt");
        end
        repeat (4) @(negedge clk);
        stop_exit = 1'b1;
        @(negedge clk);
        stop_exit = 1'b0;
        drain();

        // R10: back-to-back four-byte branches overflow
        set_size(3);
        @(negedge clk);
        br_taken = 1'b1;
        br_target = 32'h76543210;
        model_branch(32'h76543210);
        flush("R10 accepted packet");
        @(negedge clk);
        chk(trc_overflow == 1'b0, "R10 first packet fits", {31'h0, trc_overflow}, 32'h0);
        br_target = 32'hFEDCBA98;
        @(negedge clk);
        br_taken = 1'b0;
        chk(trc_overflow == 1'b1, "R10 overflow raised", {31'h0, trc_overflow}, 32'h1);
        @(negedge clk);
        chk(trc_overflow == 1'b0, "R10 overflow one cycle", {31'h0, trc_overflow}, 32'h0);
        drain();

        chk(exp_q.size() == 0, "R9 all bytes delivered", exp_q.size(), 32'h0);
        chk(trc_data == 8'h00 && !trc_valid, "R8 idle at end", {23'h0, trc_valid, trc_data}, 32'h0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule